// File: doc/BRIEF.md
# Offset DAC Range Tracker

The block holds the control word of a 6-bit offset DAC that sits in front of a capacitance-to-digital converter. With automatic tracking active it moves the DAC code when the converter's averaged result drifts toward either end of its scale. An average above the upper threshold raises the code by one step. An average below the lower threshold lowers it by one step. The step size follows the selected full-scale range, so the converter stays in the middle of its span.

Software writes and reads an 8-bit control word. Bit 7 enables the DAC and bit 6 enables automatic tracking. Bits [5:0] carry the DAC code. Tracking only runs when bit 6 is set and the adaptive-threshold mode input is high. In fixed-threshold mode the code stays where software put it. Every automatic step is written back into the code field, so a readback always shows the code that is driving the DAC.

Top module: `offset_dac_tracker`

## Requirements
- R1: Control word layout: bit 7 is DAC enable, bit 6 is auto-tracking enable, and bits [5:0] are the DAC code. `reg_rdata_o` returns the whole word, `dac_en_o` follows bit 7 and `dac_code_o` follows bits [5:0]. A write with `reg_wr_i` high updates the word on that clock edge.
- R2: After reset the control word reads 0xC0: DAC enabled, auto-tracking on, code 0.
- R3: In a cycle with `avg_valid_i` high, auto-tracking effective and `avg_data_i` strictly above 3/4 of full scale (above 0xC000 at DATA_W=16), the code rises by one step. The new code is visible after that clock edge. A value of exactly 0xC000 causes no change.
- R4: Under the same conditions, an average strictly below 1/4 of full scale (below 0x4000 at DATA_W=16) lowers the code by one step. A value of exactly 0x4000 causes no change.
- R5: The step size is 1 << `range_sel_i`, so range settings 0, 1, 2 and 3 give steps of 1, 2, 4 and 8 codes.
- R6: The code saturates. An increase that would pass 0x3F gives 0x3F, and a decrease that would go below 0 gives 0. The code never wraps.
- R7: With `adaptive_i` low (fixed-threshold mode), no automatic change takes place, whatever the state of bit 6.
- R8: With bit 6 clear, no automatic change takes place.
- R9: The code moves only in a cycle with `avg_valid_i` high, and by at most one step per such cycle.
- R10: When a register write and an adjustment fall in the same cycle, the write wins and the adjustment is dropped.
- R11: An automatic step changes only bits [5:0]. Bits 7 and 6 keep their values, and the new code appears on `reg_rdata_o`. Bit 7 does not gate tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 8 | Control word write data |
| reg_rdata_o | output | 8 | Control word readback |
| avg_valid_i | input | 1 | New averaged result strobe |
| avg_data_i | input | DATA_W | Averaged converter result |
| range_sel_i | input | RANGE_W | Full-scale range selection, sets step size |
| adaptive_i | input | 1 | High for adaptive-threshold mode, low for fixed |
| dac_code_o | output | CODE_W | Effective DAC code |
| dac_en_o | output | 1 | DAC enable |

## Verification
The bench drives the threshold values 0xC000, 0xC001, 0x4000 and 0x3FFF. An off-by-one comparison shows up as a step taken or missed at one of these points. It runs steps that would carry past 0x3F or borrow below 0. A design without saturation wraps to a small or large code there. It covers fixed-threshold mode, cleared auto bit and no valid strobe while the average is high, each of which a faulty gate would let move the code. It also puts a write and an adjustment in the same cycle, where a design with the wrong priority would show the written code plus one step.

// File: rtl/offset_dac_pkg.sv
package offset_dac_pkg;
  parameter int CODE_W = 6;
  localparam int CTRL_W = CODE_W + 2;

  typedef struct packed {
    logic              en;
    logic              auto_adj;
    logic [CODE_W-1:0] code;
  } ctrl_word_t;

  localparam ctrl_word_t CTRL_RESET = '{en: 1'b1, auto_adj: 1'b1, code: '0};
endpackage

// File: rtl/offset_dac_window.sv
module offset_dac_window #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              above_o,
  output logic              below_o
);
  localparam logic [DATA_W-1:0] HI_TH = {2'b11, {(DATA_W-2){1'b0}}};
  localparam logic [DATA_W-1:0] LO_TH = {2'b01, {(DATA_W-2){1'b0}}};

  // strict comparisons: threshold values themselves do not trigger
  assign above_o = data_i > HI_TH;
  assign below_o = data_i < LO_TH;
endmodule

// File: rtl/offset_dac_stepper.sv
module offset_dac_stepper #(
  parameter int CODE_W  = 6,
  parameter int RANGE_W = 2
) (
  input  logic [CODE_W-1:0]  code_i,
  input  logic [RANGE_W-1:0] range_i,
  input  logic               up_i,
  input  logic               down_i,
  output logic [CODE_W-1:0]  code_o
);
  localparam int MAX_CODE = (1 << CODE_W) - 1;

  int step;
  int cur;
  int nxt;

  always_comb begin
    step = 1 << range_i;
    cur  = int'(code_i);
    nxt  = cur;
    if (up_i) nxt = (cur + step > MAX_CODE) ? MAX_CODE : cur + step;
    else if (down_i) nxt = (cur < step) ? 0 : cur - step;
    code_o = CODE_W'(nxt);
  end

  // R6: saturation never lands on the far side of the current code
  always_comb begin
    if (up_i && !down_i) a_up_mono_r6: assert (code_o >= code_i);
    if (down_i && !up_i) a_dn_mono_r6: assert (code_o <= code_i);
  end
endmodule

// File: rtl/offset_dac_ctrl_reg.sv
module offset_dac_ctrl_reg
  import offset_dac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  ctrl_word_t        wdata_i,
  input  logic              adj_i,
  input  logic [CODE_W-1:0] adj_code_i,
  output ctrl_word_t        q_o
);
  ctrl_word_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= CTRL_RESET;
    else if (wr_i) q <= wdata_i;
    else if (adj_i) q.code <= adj_code_i;
  end

  assign q_o = q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !adj_i) |=> $stable(q));
  p_write_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (q == $past(wdata_i)));
  p_flags_kept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && adj_i) |=> ($stable(q.en) && $stable(q.auto_adj)));
endmodule

// File: rtl/offset_dac_tracker.sv
module offset_dac_tracker
  import offset_dac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int RANGE_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [CTRL_W-1:0]  reg_wdata_i,
  output logic [CTRL_W-1:0]  reg_rdata_o,
  input  logic               avg_valid_i,
  input  logic [DATA_W-1:0]  avg_data_i,
  input  logic [RANGE_W-1:0] range_sel_i,
  input  logic               adaptive_i,
  output logic [CODE_W-1:0]  dac_code_o,
  output logic               dac_en_o
);
  localparam logic [CODE_W-1:0] MAX_CODE = '1;

  ctrl_word_t        ctrl;
  logic              above;
  logic              below;
  logic              track_on;
  logic              adj;
  logic [CODE_W-1:0] next_code;

  offset_dac_window #(.DATA_W(DATA_W)) u_window (
    .data_i  (avg_data_i),
    .above_o (above),
    .below_o (below)
  );

  offset_dac_stepper #(.CODE_W(CODE_W), .RANGE_W(RANGE_W)) u_stepper (
    .code_i  (ctrl.code),
    .range_i (range_sel_i),
    .up_i    (above),
    .down_i  (below),
    .code_o  (next_code)
  );

  // tracking needs both the auto bit and adaptive mode
  assign track_on = ctrl.auto_adj & adaptive_i;
  assign adj      = avg_valid_i & track_on & (above | below);

  offset_dac_ctrl_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .wdata_i    (ctrl_word_t'(reg_wdata_i)),
    .adj_i      (adj),
    .adj_code_i (next_code),
    .q_o        (ctrl)
  );

  assign reg_rdata_o = ctrl;
  assign dac_code_o  = ctrl.code;
  assign dac_en_o    = ctrl.en;

  p_fixed_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adaptive_i && !reg_wr_i) |=> $stable(dac_code_o));
  p_auto_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_rdata_o[CODE_W] && !reg_wr_i) |=> $stable(dac_code_o));
  p_top_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_code_o == MAX_CODE && !reg_wr_i && !below) |=> (dac_code_o == MAX_CODE));
  p_no_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!avg_valid_i && !reg_wr_i) |=> $stable(reg_rdata_o));
endmodule

// File: tb/sim_offset_dac_tracker.sv
module sim_offset_dac_tracker;
  localparam int DATA_W = 16;
  localparam int RANGE_W = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr = 1'b0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic              valid = 1'b0;
  logic [DATA_W-1:0] data = '0;
  logic [1:0]        rng = '0;
  logic              adaptive = 1'b1;
  logic [5:0]        code;
  logic              en;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] model = 8'hC0;

  always #2.5 clk = ~clk;

  offset_dac_tracker #(.DATA_W(DATA_W), .RANGE_W(RANGE_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .avg_valid_i(valid), .avg_data_i(data),
    .range_sel_i(rng), .adaptive_i(adaptive), .dac_code_o(code), .dac_en_o(en)
  );

  function automatic logic [7:0] predict(logic [7:0] cur, logic w, logic [7:0] wd,
      logic v, logic [DATA_W-1:0] d, logic [1:0] r, logic ad);
    int c;
    int st;
    if (w) return wd;
    c  = int'(cur[5:0]);
    st = 1 << r;
    if (v && ad && cur[6]) begin
      if (d > 16'hC000) c = (c + st > 63) ? 63 : c + st;
      else if (d < 16'h4000) c = (c < st) ? 0 : c - st;
    end
    return {cur[7:6], 6'(c)};
  endfunction

  task automatic compare(logic [7:0] e, string tag);
    checks++;
    if (rdata !== e || code !== e[5:0] || en !== e[7]) begin
      fails++;
      $display("FAIL %s: rdata=%h code=%h en=%b expected %h", tag, rdata, code, en, e);
    end
  endtask

  // driver: one cycle of stimulus, expectation pushed to scoreboard
  task automatic cyc(logic w, logic [7:0] wd, logic v, logic [DATA_W-1:0] d,
      logic [1:0] r, logic ad, string tag);
    @(negedge clk);
    wr = w; wdata = wd; valid = v; data = d; rng = r; adaptive = ad;
    model = predict(model, w, wd, v, d, r, ad);
    exp_q.push_back(model);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; valid = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    compare(8'hC0, "R2 reset value");
    cyc(0, 0, 1, 16'hC001, 0, 1, "R3 above upper threshold");
    cyc(0, 0, 1, 16'hC000, 0, 1, "R3 at upper threshold");
    cyc(0, 0, 1, 16'h3FFF, 0, 1, "R4 below lower threshold");
    cyc(0, 0, 1, 16'h4000, 0, 1, "R4 at lower threshold");
    cyc(1, 8'hD4, 0, 16'h8000, 0, 1, "R1 write readback");
    cyc(0, 0, 1, 16'hFFFF, 1, 1, "R5 step 2");
    cyc(0, 0, 1, 16'hFFFF, 2, 1, "R5 step 4");
    cyc(0, 0, 1, 16'hFFFF, 3, 1, "R5 step 8");
    cyc(0, 0, 1, 16'h0000, 3, 1, "R5 step 8 down");
    cyc(1, 8'hFE, 0, 16'h0, 0, 1, "R1 write near top");
    cyc(0, 0, 1, 16'hFFFF, 3, 1, "R6 saturate at 0x3F");
    cyc(0, 0, 1, 16'hFFFF, 3, 1, "R6 hold at 0x3F");
    cyc(1, 8'hC3, 0, 16'h0, 0, 1, "R1 write near bottom");
    cyc(0, 0, 1, 16'h0000, 2, 1, "R6 saturate at 0");
    cyc(0, 0, 1, 16'h0000, 0, 1, "R6 hold at 0");
    cyc(1, 8'hD0, 0, 16'h0, 0, 0, "R1 write in fixed mode");
    cyc(0, 0, 1, 16'hFFFF, 0, 0, "R7 fixed mode ignores high average");
    cyc(0, 0, 1, 16'h0000, 0, 0, "R7 fixed mode ignores low average");
    cyc(1, 8'h90, 0, 16'h0, 0, 1, "R1 write auto off");
    cyc(0, 0, 1, 16'hFFFF, 0, 1, "R8 auto bit clear ignores high average");
    cyc(1, 8'h50, 0, 16'h0, 0, 1, "R1 write enable off");
    cyc(0, 0, 1, 16'hFFFF, 0, 1, "R11 tracking with enable off keeps flags");
    cyc(0, 0, 0, 16'hFFFF, 3, 1, "R9 no strobe no change");
    cyc(0, 0, 1, 16'hFFFF, 0, 1, "R9 single step per strobe");
    cyc(1, 8'hE0, 1, 16'hFFFF, 3, 1, "R10 write beats adjustment");
    cyc(0, 0, 1, 16'hFFFF, 0, 1, "R11 readback after step");
    repeat (3) @(posedge clk);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule